// File: doc/BRIEF.md
# Serial Display Command/Data Receiver

This block receives the serial host link of a display controller. While the active-low chip select is held low, the block samples one bit of the serial data line on each rising edge of the serial clock, most significant bit first. Every eighth bit completes a byte. The block marks each byte as either a controller command or a display-data byte. The serial side runs on the serial clock. Each finished byte goes to the system clock domain through a toggle flag and a synchroniser. On the system side it appears as a single-cycle strobe that carries the byte, its command/data flag and a column-advance pulse.

A static mode input selects how bytes are classified. In select-pin mode, the level of a register-select input decides the class of each byte. In pinless mode, every byte is a command unless a counted burst is open. The host opens a burst by sending the direction opcode 0xE8 followed directly by a count byte N. The next N bytes are then display data, and the link returns to commands without further action from the host.

The classifier state machine has three states: `ST_CMD` (bytes are commands), `ST_DIR` (the direction opcode was seen and the next byte is the count) and `ST_BURST` (counted data bytes are in flight). Its transitions are: `ST_CMD`→`ST_DIR` on byte 0xE8; `ST_DIR`→`ST_CMD` on count 0; `ST_DIR`→`ST_BURST` on a nonzero count; `ST_BURST`→`ST_CMD` on the last counted byte. In select-pin mode the machine is forced to `ST_CMD`.

Top module: `sdisp_rx`

## Requirements
- R1: While `cs_n` is high, the bit counter and shift register are cleared and serial clock edges are ignored, so a partially shifted byte is discarded and the next byte is assembled from eight fresh bits.
- R2: Bits are sampled on the rising edge of `sclk`, first bit into bit 7 of `rx_byte`. The eighth rising edge with `cs_n` low completes a byte.
- R3: With `pin_sel_mode`=1, a byte is data (`rx_is_data`=1) when `reg_sel` is high at its eighth edge and a command (`rx_is_data`=0) when `reg_sel` is low.
- R4: With `pin_sel_mode`=0 and no burst open, every byte is reported as a command.
- R5: With `pin_sel_mode`=0, the byte 0xE8 followed directly by a count byte N (1..255) makes the next N bytes data. The byte after them is a command again. Both the opcode and the count byte are reported as commands.
- R6: With `pin_sel_mode`=0, a count byte of 0 after 0xE8 opens no burst, and the next byte is a command.
- R7: A 0xE8 byte received inside an open burst is data and does not restart or lengthen the burst.
- R8: `col_adv` pulses for one `clk` cycle together with each data byte's `rx_valid` and never for a command byte.
- R9: Each received byte produces exactly one single-cycle `rx_valid` pulse on `clk`, with `rx_byte` and `rx_is_data` valid in that cycle.
- R10: After `rst_n` is asserted, `rx_valid`, `rx_byte`, `rx_is_data` and `col_adv` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pin_sel_mode | input | 1 | Static mode: 1 = register-select pin marks bytes, 0 = counted bursts |
| cs_n | input | 1 | Active-low chip select; high clears the bit assembly |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdin | input | 1 | Serial data, MSB first |
| reg_sel | input | 1 | Register select: high = data, low = command (select-pin mode) |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |
| col_adv | output | 1 | Column address advance pulse for each data byte |

## Verification
Two events can fall on the same eighth serial edge: the end of a counted burst and the classification of the byte that completes it. The same holds for a direction opcode that arrives as burst payload. The bench provokes these cases by sweeping burst lengths 0 to 6 and 255, and by placing 0xE8 both as the last payload byte and directly after a burst. A reference model of the burst counter in the bench computes the class every byte should receive. The same strobe cycle also carries the column-advance pulse, so every `rx_valid` is compared against the expected byte, flag and `col_adv`, and any `col_adv` without a data strobe counts as a failure.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;

    localparam int SD_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_DIR   = 2'd1,
        ST_BURST = 2'd2
    } sd_state_e;

endpackage

// File: rtl/sdisp_shift.sv
module sdisp_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdin,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_word
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    // Chip select high holds the assembly in reset (R1)
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_W-3:0], sdin};
        end
    end

    // Eighth bit completes the byte on this edge, MSB first (R2)
    always_comb begin
        byte_done = !cs_n && (bit_cnt == LAST_BIT);
        byte_word = {shreg, sdin};
    end

endmodule

// File: rtl/sdisp_class.sv
module sdisp_class
    import sdisp_pkg::*;
#(
    parameter int              BYTE_W = 8,
    parameter logic [BYTE_W-1:0] DIR_OPCODE = 8'hE8
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              pin_sel_mode,
    input  logic              reg_sel,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_word,
    output logic              is_data
);

    sd_state_e         state, state_nx;
    logic [BYTE_W-1:0] remain, remain_nx;

    // State register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CMD;
            remain <= '0;
        end else begin
            state  <= state_nx;
            remain <= remain_nx;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nx  = state;
        remain_nx = remain;
        unique case (state)
            ST_CMD: begin
                if (byte_done && byte_word == DIR_OPCODE) state_nx = ST_DIR;
            end
            ST_DIR: begin
                if (byte_done) begin
                    if (byte_word == '0) begin
                        state_nx = ST_CMD;
                    end else begin
                        state_nx  = ST_BURST;
                        remain_nx = byte_word;
                    end
                end
            end
            ST_BURST: begin
                if (byte_done) begin
                    remain_nx = remain - 1'b1;
                    if (remain == BYTE_W'(1)) state_nx = ST_CMD;
                end
            end
            default: state_nx = ST_CMD;
        endcase
        if (pin_sel_mode) begin
            state_nx  = ST_CMD;
            remain_nx = '0;
        end
        is_data = pin_sel_mode ? reg_sel : (state == ST_BURST);
    end

    assert_pin_idle_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        pin_sel_mode |=> state == ST_CMD);

    assert_cmd_default_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        (!pin_sel_mode && state != ST_BURST) |-> !is_data);

    assert_burst_live_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        state == ST_BURST |-> remain != '0);

    assert_burst_exit_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        (!pin_sel_mode && state == ST_BURST && byte_done && remain == BYTE_W'(1))
        |=> state == ST_CMD);

    assert_zero_count_R6: assert property (@(posedge sclk) disable iff (!rst_n)
        (!pin_sel_mode && state == ST_DIR && byte_done && byte_word == '0)
        |=> state == ST_CMD);

    assert_no_restart_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        (!pin_sel_mode && state == ST_BURST && remain != BYTE_W'(1) && byte_done)
        |=> (state == ST_BURST && remain == $past(remain) - 1'b1));

endmodule

// File: rtl/sdisp_xfer.sv
module sdisp_xfer #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SYNC_W     = SYNC_STAGES + 1
) (
    input  logic              sclk,
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_word,
    input  logic              byte_is_data,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              col_adv
);

    // Serial-clock side: hold the byte, flip the toggle
    logic [BYTE_W-1:0] hold_word;
    logic              hold_data;
    logic              tog;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_data <= 1'b0;
            tog       <= 1'b0;
        end else if (byte_done) begin
            hold_word <= byte_word;
            hold_data <= byte_is_data;
            tog       <= ~tog;
        end
    end

    // System-clock side: synchroniser chain plus edge detect
    logic [SYNC_W-1:0] sync;
    logic              tog_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= '0;
        else        sync <= {sync[SYNC_W-2:0], tog};
    end

    always_comb tog_edge = sync[SYNC_W-1] ^ sync[SYNC_W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_byte    <= '0;
            rx_is_data <= 1'b0;
            col_adv    <= 1'b0;
        end else begin
            rx_valid <= tog_edge;
            col_adv  <= tog_edge && hold_data;
            if (tog_edge) begin
                rx_byte    <= hold_word;
                rx_is_data <= hold_data;
            end
        end
    end

    assert_col_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_adv |-> (rx_valid && rx_is_data));

    assert_data_has_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_data) |-> col_adv);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/sdisp_rx.sv
module sdisp_rx
    import sdisp_pkg::*;
#(
    parameter int                   BYTE_W      = SD_BYTE_W,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0]    DIR_OPCODE  = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_sel_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              reg_sel,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              col_adv
);

    logic              byte_done;
    logic [BYTE_W-1:0] byte_word;
    logic              byte_is_data;

    sdisp_shift #(.BYTE_W(BYTE_W)) u_shift (
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdin      (sdin),
        .byte_done (byte_done),
        .byte_word (byte_word)
    );

    sdisp_class #(.BYTE_W(BYTE_W), .DIR_OPCODE(DIR_OPCODE)) u_class (
        .sclk         (sclk),
        .rst_n        (rst_n),
        .pin_sel_mode (pin_sel_mode),
        .reg_sel      (reg_sel),
        .byte_done    (byte_done),
        .byte_word    (byte_word),
        .is_data      (byte_is_data)
    );

    sdisp_xfer #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .sclk         (sclk),
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done    (byte_done),
        .byte_word    (byte_word),
        .byte_is_data (byte_is_data),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_is_data   (rx_is_data),
        .col_adv      (col_adv)
    );

endmodule

// File: tb/sdisp_rx_tb.sv
module sdisp_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_sel_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       reg_sel = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rx_is_data;
    logic       col_adv;

    always #10 clk = ~clk;

    sdisp_rx u_dut (
        .clk(clk), .rst_n(rst_n), .pin_sel_mode(pin_sel_mode), .cs_n(cs_n),
        .sclk(sclk), .sdin(sdin), .reg_sel(reg_sel), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_is_data(rx_is_data), .col_adv(col_adv)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // Expected byte stream
    logic [7:0] exp_byte [0:1023];
    logic       exp_data [0:1023];
    int         wr_idx = 0;
    int         rd_idx = 0;

    // Bench model of the counted burst
    int ms = 0;   // 0 command, 1 count pending, 2 burst
    int mr = 0;

    task automatic note_fail(input string req, input string what, input int act, input int exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic sclk_bit(input logic b);
        sdin = b;
        #60 sclk = 1'b1;
        #60 sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic r);
        logic e;
        if (pin_sel_mode) begin
            e = r;
        end else begin
            case (ms)
                0: begin e = 1'b0; if (v == 8'hE8) ms = 1; end
                1: begin
                    e = 1'b0;
                    if (v == 8'h00) ms = 0;
                    else begin ms = 2; mr = int'(v); end
                end
                default: begin e = 1'b1; mr--; if (mr == 0) ms = 0; end
            endcase
        end
        exp_byte[wr_idx] = v;
        exp_data[wr_idx] = e;
        wr_idx++;
        reg_sel = r;
        for (int i = 7; i >= 0; i--) sclk_bit(v[i]);
        #200;
    endtask

    task automatic drain();
        int t = 0;
        while (rd_idx != wr_idx && t < 2000) begin
            @(posedge clk);
            t++;
        end
        repeat (10) @(posedge clk);
        checks++;
        if (rd_idx != wr_idx) note_fail("R9", "bytes delivered", rd_idx, wr_idx);
    endtask

    // Monitor, sampled on the falling edge of clk
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (rx_valid) begin
                checks++;
                if (rd_idx >= wr_idx) begin
                    note_fail("R1", "unexpected byte", int'(rx_byte), 0);
                end else begin
                    if (rx_byte !== exp_byte[rd_idx])
                        note_fail("R2", "byte value", int'(rx_byte), int'(exp_byte[rd_idx]));
                    if (rx_is_data !== exp_data[rd_idx])
                        note_fail(exp_data[rd_idx] ? "R5" : "R4", "data flag",
                                  int'(rx_is_data), int'(exp_data[rd_idx]));
                    if (col_adv !== exp_data[rd_idx])
                        note_fail("R8", "column advance", int'(col_adv), int'(exp_data[rd_idx]));
                    rd_idx++;
                end
            end else if (col_adv) begin
                checks++;
                note_fail("R8", "column advance without strobe", 1, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({rx_valid, rx_byte, rx_is_data, col_adv} !== 11'd0)
            note_fail("R10", "reset outputs", int'({rx_valid, rx_byte, rx_is_data, col_adv}), 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R3: select-pin mode, every byte value with a mixed select pattern
        pin_sel_mode = 1'b1;
        cs_n = 1'b0;
        #100;
        for (int v = 0; v < 256; v++) send_byte(8'(v), v[0] ^ v[3]);
        cs_n = 1'b1;
        drain();

        // R4: pinless mode, plain commands
        pin_sel_mode = 1'b0;
        #200 cs_n = 1'b0;
        #100;
        send_byte(8'h3C, 1'b1);
        send_byte(8'hE7, 1'b1);
        send_byte(8'hA5, 1'b0);

        // R5/R6: burst length sweep, payload ends with 0xE8 (R7)
        for (int n = 0; n <= 6; n++) begin
            send_byte(8'hE8, 1'b0);
            send_byte(8'(n), 1'b0);
            for (int i = 0; i < n; i++)
                send_byte((i == n - 1) ? 8'hE8 : 8'((n * 7 + i * 13) & 8'hFF), 1'b0);
            send_byte(8'h11, 1'b1);
        end
        drain();

        // R7: opcode inside burst and again right after it
        send_byte(8'hE8, 1'b0);
        send_byte(8'd3, 1'b0);
        send_byte(8'hE8, 1'b0);
        send_byte(8'h02, 1'b0);
        send_byte(8'h77, 1'b0);
        send_byte(8'hE8, 1'b0);
        send_byte(8'd2, 1'b0);
        send_byte(8'h90, 1'b0);
        send_byte(8'h91, 1'b0);
        send_byte(8'h92, 1'b0);
        drain();

        // R5: longest burst
        send_byte(8'hE8, 1'b0);
        send_byte(8'd255, 1'b0);
        for (int i = 0; i < 255; i++) send_byte(8'((i * 29 + 5) & 8'hFF), 1'b0);
        send_byte(8'h42, 1'b0);
        drain();

        // R1: partial byte aborted by chip select, clocks ignored while high
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        cs_n = 1'b1;
        #100;
        for (int i = 0; i < 11; i++) sclk_bit(i[0]);
        #100 cs_n = 1'b0;
        #100;
        send_byte(8'h5A, 1'b0);
        drain();
        checks++;
        if (rd_idx != wr_idx) note_fail("R1", "byte count after abort", rd_idx, wr_idx);

        // R1: burst state kept across chip select, assembly restarted
        send_byte(8'hE8, 1'b0);
        send_byte(8'd1, 1'b0);
        sclk_bit(1'b0);
        cs_n = 1'b1;
        #200 cs_n = 1'b0;
        #100;
        send_byte(8'hC3, 1'b0);
        send_byte(8'hC4, 1'b0);
        cs_n = 1'b1;
        drain();

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule